// File: doc/BRIEF.md
# Subband Write DMA Controller

This block moves the coefficients leaving a wavelet filter stage into an external RAM. The filter presents a low-pass and a high-pass result in turn along each output row. The controller tells the source which band it expects next, accepts each word on a data-ready pulse, and issues a single-cycle write with a registered address and data. Each band has its own address pointer. A small ROM holds the base address of each stream, and both pointers reload from it on every new-frame strobe. An adder then moves a stream's pointer one word forward after each write to that stream.

A frame-level state machine follows where the data stands in the frame: idle before the first strobe, first row, middle rows, last row, and done. Some data carries an out-of-frame flag, and some is high-pass data on the last row. Such data still uses its transfer slot, but the DMA treats its address as invalid: no chip select, no write, and the pointer holds. When the last row completes, further data is ignored until the next new-frame strobe.

Top module: `subband_wr_dma`

## Requirements
- R1: After reset, `ram_cs` and `ram_we` are 0, `band_sel` is 0, and `data_rdy` pulses are ignored (no write) until the first `frame_start`.
- R2: A `frame_start` loads the stream pointers from the base ROM. The first low-pass write of the frame goes to `LO_BASE` and the first high-pass write goes to `HI_BASE`.
- R3: `band_sel` (0 = low-pass expected, 1 = high-pass expected) is 0 at the start of every row and toggles after each accepted `data_rdy`. A row is `ROW_XFERS` transfers long, and `ROW_XFERS` is even.
- R4: A written transfer gives `ram_cs` = `ram_we` = 1 for exactly the one cycle after its `data_rdy` edge. In that cycle `ram_addr` is the stream pointer and `ram_data` is the captured `data_in`. In every other cycle `ram_cs` = `ram_we` = 0.
- R5: Each write to a stream advances that stream's pointer by one word. The other stream's pointer is unchanged.
- R6: A transfer with `data_in_frame` = 0 is not written and does not advance a pointer, but it still uses its slot (the band toggles).
- R7: On the last row of the frame (row `ROWS`-1), high-pass transfers are not written and do not advance the high-pass pointer. Low-pass transfers on that row are written normally.
- R8: After the last row's final transfer, `data_rdy` is ignored until the next `frame_start`.
- R9: A `frame_start` at any time restarts the frame: first row, low band, pointers reloaded. A `data_rdy` in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | New-frame strobe, one cycle |
| data_rdy | input | 1 | A result word is present on `data_in` |
| data_in_frame | input | 1 | 1 when the presented word lies inside the frame |
| data_in | input | DATA_W | Result word from the filter |
| band_sel | output | 1 | Band expected next: 0 low-pass, 1 high-pass |
| ram_addr | output | ADDR_W | External RAM word address |
| ram_data | output | DATA_W | External RAM write data |
| ram_cs | output | 1 | RAM chip select, active high |
| ram_we | output | 1 | RAM write strobe (1 = write) |

## Verification
On every cycle, the assertions check the pointer rules: reload on a frame strobe, a +1 step only on a write to that stream, and hold otherwise. They also check the one-cycle write pulse with its address and data captured together, the band toggle, the suppressed last-row high-pass writes, and the silence while idle or done. The assertions cannot show that addresses follow the correct sequence over a whole frame, in which a prior stream was interleaved with dropped and out-of-frame slots. Only the bench scenarios show this, together with the restart from a strobe in the middle of a frame and the ignored strobe-coincident data. The bench scoreboard predicts each slot's outcome from its own model of rows, bands and pointers.

// File: rtl/sbdma_pkg.sv
package sbdma_pkg;

  // frame-position states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIRST = 3'd1,
    ST_MID   = 3'd2,
    ST_LAST  = 3'd3,
    ST_DONE  = 3'd4
  } frame_st_t;

  localparam int NUM_STREAMS = 2;
  localparam logic BAND_LO = 1'b0;
  localparam logic BAND_HI = 1'b1;

  // base-address ROM contents: stream 0 low-pass, stream 1 high-pass
  function automatic int f_rom_base(input int idx, input int lo, input int hi);
    return (idx == 0) ? lo : hi;
  endfunction

  // adder producing the next word address
  function automatic logic [31:0] f_next_addr(input logic [31:0] cur);
    return cur + 32'd1;
  endfunction

  // address is valid only for in-frame data that is not last-row high-pass
  function automatic logic f_write_ok(input logic in_frame,
                                      input logic on_last_row,
                                      input logic band);
    return in_frame && !(on_last_row && (band == BAND_HI));
  endfunction

  // state entered once a row completes
  function automatic frame_st_t f_row_done_next(input frame_st_t cur,
                                                input logic next_is_last);
    frame_st_t nxt;
    if (cur == ST_LAST)   nxt = ST_DONE;
    else if (next_is_last) nxt = ST_LAST;
    else                   nxt = ST_MID;
    return nxt;
  endfunction

endpackage

// File: rtl/sbdma_frame_fsm.sv
module sbdma_frame_fsm
  import sbdma_pkg::*;
#(
  parameter int ROW_XFERS = 4,
  parameter int ROWS      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic data_rdy,
  output logic band_sel,
  output logic busy,
  output logic last_row,
  output logic slot_evt
);
  localparam int COL_W = (ROW_XFERS > 1) ? $clog2(ROW_XFERS) : 1;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [COL_W-1:0] COL_END  = COL_W'(ROW_XFERS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  frame_st_t        st_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             band_q;
  logic             row_end;
  logic [ROW_W-1:0] row_inc;

  assign busy     = (st_q == ST_FIRST) || (st_q == ST_MID) || (st_q == ST_LAST);
  assign last_row = (st_q == ST_LAST);
  assign slot_evt = data_rdy && busy && !frame_start;
  assign row_end  = (col_q == COL_END);
  assign row_inc  = row_q + 1'b1;
  assign band_sel = band_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      row_q  <= '0;
      band_q <= BAND_LO;
    end else if (frame_start) begin
      st_q   <= ST_FIRST;
      col_q  <= '0;
      row_q  <= '0;
      band_q <= BAND_LO;
    end else if (slot_evt) begin
      if (row_end) begin
        col_q  <= '0;
        band_q <= BAND_LO;
        row_q  <= row_inc;
        st_q   <= f_row_done_next(st_q, row_inc == ROW_LAST);
      end else begin
        col_q  <= col_q + 1'b1;
        band_q <= ~band_q;
      end
    end
  end

  // every accepted slot flips the band (rows hold an even count)
  AST_BAND_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_evt |=> (band_sel != $past(band_sel))); // R3

  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (busy && !last_row || ROWS < 2) && band_sel == BAND_LO); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) && !frame_start |=> (st_q == ST_DONE)); // R8

endmodule

// File: rtl/sbdma_addr_gen.sv
module sbdma_addr_gen
  import sbdma_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LO_BASE = 0,
  parameter int HI_BASE = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              band,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] ptr_q [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] step_v;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(f_rom_base(s, LO_BASE, HI_BASE));

    assign step_v[s] = adv && (band == 1'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q[s] <= BASE;
      else if (load)       ptr_q[s] <= BASE;
      else if (step_v[s])  ptr_q[s] <= ADDR_W'(f_next_addr(32'(ptr_q[s])));
    end

    AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ptr_q[s] == BASE); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !load && step_v[s] |=> ptr_q[s] == ADDR_W'($past(ptr_q[s]) + 1'b1)); // R5

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !step_v[s] |=> $stable(ptr_q[s])); // R6
  end

  assign cur_addr = ptr_q[band];

endmodule

// File: rtl/sbdma_wr_port.sv
module sbdma_wr_port #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_data,
  output logic              ram_cs,
  output logic              ram_we
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_cs   <= 1'b0;
      ram_we   <= 1'b0;
      ram_addr <= '0;
      ram_data <= '0;
    end else begin
      ram_cs <= wr_go;
      ram_we <= wr_go;
      if (wr_go) begin
        ram_addr <= addr_in;
        ram_data <= wdata_in;
      end
    end
  end

  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> ram_cs && ram_we && ram_addr == $past(addr_in)
              && ram_data == $past(wdata_in)); // R4

  AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> !ram_cs && !ram_we); // R4

endmodule

// File: rtl/subband_wr_dma.sv
module subband_wr_dma
  import sbdma_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 10,
  parameter int ROW_XFERS = 4,
  parameter int ROWS      = 3,
  parameter int LO_BASE   = 64,
  parameter int HI_BASE   = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              data_rdy,
  input  logic              data_in_frame,
  input  logic [DATA_W-1:0] data_in,
  output logic              band_sel,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_data,
  output logic              ram_cs,
  output logic              ram_we
);
  logic busy;
  logic last_row;
  logic slot_evt;
  logic wr_ok;
  logic [ADDR_W-1:0] cur_addr;

  sbdma_frame_fsm #(.ROW_XFERS(ROW_XFERS), .ROWS(ROWS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .data_rdy(data_rdy),
    .band_sel(band_sel), .busy(busy), .last_row(last_row), .slot_evt(slot_evt)
  );

  // DMA on: valid address for this slot
  assign wr_ok = slot_evt && f_write_ok(data_in_frame, last_row, band_sel);

  sbdma_addr_gen #(.ADDR_W(ADDR_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .adv(wr_ok),
    .band(band_sel), .cur_addr(cur_addr)
  );

  sbdma_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_ok), .addr_in(cur_addr),
    .wdata_in(data_in), .ram_addr(ram_addr), .ram_data(ram_data),
    .ram_cs(ram_cs), .ram_we(ram_we)
  );

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy && !busy |=> !ram_cs); // R8

  AST_LAST_HI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    last_row && band_sel == BAND_HI |=> !ram_cs); // R7

  AST_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !data_in_frame |=> !ram_cs); // R6

  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !ram_cs); // R9

  AST_CS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> $past(data_rdy) && !$past(frame_start)); // R4

endmodule

// File: tb/subband_wr_dma_bench.sv
module subband_wr_dma_bench;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int RX = 4;
  localparam int NR = 3;
  localparam int LB = 64;
  localparam int HB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic data_rdy = 1'b0;
  logic data_in_frame = 1'b1;
  logic [DW-1:0] data_in = '0;
  logic band_sel;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_data;
  logic ram_cs, ram_we;

  always #2 clk = ~clk;  // 250 MHz

  subband_wr_dma #(.DATA_W(DW), .ADDR_W(AW), .ROW_XFERS(RX), .ROWS(NR),
                   .LO_BASE(LB), .HI_BASE(HB)) u_subband_wr_dma (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .data_rdy(data_rdy),
    .data_in_frame(data_in_frame), .data_in(data_in), .band_sel(band_sel),
    .ram_addr(ram_addr), .ram_data(ram_data), .ram_cs(ram_cs), .ram_we(ram_we)
  );

  typedef struct {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } slot_t;

  slot_t sb_q[$];
  int checks = 0;
  int errors = 0;

  // bench model of the frame
  bit          m_active = 0;
  bit          m_band = 0;
  int          m_col = 0;
  int          m_row = 0;
  logic [AW-1:0] m_lo, m_hi;
  bit          m_lo_first, m_hi_first;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_frame();
    m_active = 1; m_band = 0; m_col = 0; m_row = 0;
    m_lo = AW'(LB); m_hi = AW'(HB); m_lo_first = 1; m_hi_first = 1;
  endtask

  // drive one slot at a falling edge; data_rdy stays high until stop()
  task automatic send(input logic [DW-1:0] d, input logic inf);
    slot_t it;
    @(negedge clk);
    if (m_active) chk(band_sel == m_band, "R3", "band_sel", band_sel, m_band);
    data_rdy = 1'b1; data_in = d; data_in_frame = inf;
    it.wr = 0; it.addr = '0; it.data = d; it.tag = "R8";
    if (m_active) begin
      if (!inf) it.tag = "R6";
      else if (m_row == NR - 1 && m_band) it.tag = "R7";
      else begin
        it.wr = 1;
        if (m_band) begin
          it.addr = m_hi; it.tag = m_hi_first ? "R2" : "R5";
          m_hi = m_hi + 1'b1; m_hi_first = 0;
        end else begin
          it.addr = m_lo; it.tag = m_lo_first ? "R2" : "R5";
          m_lo = m_lo + 1'b1; m_lo_first = 0;
        end
      end
      if (m_col == RX - 1) begin
        m_col = 0; m_band = 0; m_row++;
        if (m_row == NR) m_active = 0;
      end else begin
        m_col++; m_band = ~m_band;
      end
    end
    sb_q.push_back(it);
  endtask

  task automatic stop();
    @(negedge clk);
    data_rdy = 1'b0; data_in_frame = 1'b1;
  endtask

  // new-frame strobe, optionally with coincident data (which is ignored)
  task automatic strobe(input bit with_data);
    @(negedge clk);
    frame_start = 1'b1; data_rdy = with_data; data_in = 16'hDEAD;
    model_frame();
    @(negedge clk);
    frame_start = 1'b0; data_rdy = 1'b0;
    chk(ram_cs == 1'b0, "R9", "cs after strobe", ram_cs, 0);
    chk(band_sel == 1'b0, "R9", "band after strobe", band_sel, 0);
  endtask

  // monitor: compare each slot outcome one edge later
  bit prev_slot = 0;
  always @(posedge clk) prev_slot <= data_rdy && !frame_start;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_slot) begin
        slot_t it;
        if (sb_q.size() == 0) begin
          chk(0, "R4", "slot without model item", 0, 1);
        end else begin
          it = sb_q.pop_front();
          chk(ram_cs == it.wr, it.tag, "ram_cs", ram_cs, it.wr);
          chk(ram_we == it.wr, "R4", "ram_we", ram_we, it.wr);
          if (it.wr && ram_cs) begin
            chk(ram_addr == it.addr, it.tag, "ram_addr", ram_addr, it.addr);
            chk(ram_data == it.data, "R4", "ram_data", ram_data, it.data);
          end
        end
      end else begin
        chk(!ram_cs && !ram_we, "R4", "stray write", ram_cs, 0);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_cs == 0 && ram_we == 0, "R1", "cs/we in reset", ram_cs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(band_sel == 0, "R1", "band after reset", band_sel, 0);
    // R1: data before any frame is ignored
    send(16'h1111, 1); send(16'h2222, 1); stop();

    // full frame, back-to-back, all in frame: R2 R3 R4 R5 R7
    strobe(0);
    for (int k = 0; k < RX * NR; k++) send(DW'(16'hA000 + k), 1);
    stop();
    // R8: after last row, data ignored
    send(16'h3333, 1); stop();
    send(16'h4444, 1); stop();

    // second frame with gaps and out-of-frame slots: R6
    strobe(0);
    send(16'hB000, 1); send(16'hB001, 0); stop();
    send(16'hB002, 0); stop();
    send(16'hB003, 1); send(16'hB004, 1); send(16'hB005, 1); stop();
    // R9: restart mid-frame with coincident data
    strobe(1);
    for (int k = 0; k < RX * NR; k++) begin
      send(DW'(16'hC000 + k), (k % 3) != 1);
      if (k % 4 == 2) stop();
    end
    stop();
    send(16'h5555, 1); stop();
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R4", "scoreboard drained", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule